// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block recreates the three classic real-time-clock interrupt sources (seconds update, time-of-day alarm and periodic) on top of a free-running counter and a one-shot comparator. It owns the comparator target and its enable. Whenever the comparator reports a match through `tick_i`, the block pushes the target forward by one tick interval. It then polls the wall-clock time it is given and decides which sources fire on that tick.

The base tick runs at 64 Hz, so its interval is one second of counter ticks shifted right by six. Periodic rates at or below 64 Hz divide the base tick by a programmed divide value. Higher rates swap the base interval for a caller-supplied interval and then fire on every tick. If the counter has already run past the new target when a tick is serviced, the target keeps stepping forward until it leads the counter again. Every extra step is reported as a lost tick and is credited to the periodic divider.

Top module: `rtc_irq_emul`

## Requirements
- R1: When any enable goes high while all were clear, `cmp_en_o` rises on the next edge and `cmp_target_o` becomes `count_i` plus the interval. The interval is `TICKS_PER_SEC >> 6`, or `per_delta_i` when periodic is enabled and `per_div_i` is 0.
- R2: With all three enables clear, `cmp_en_o` is 0 from the next edge on. A `tick_i` pulse then produces no interrupt and leaves `lost_o` and `cmp_target_o` unchanged.
- R3: A serviced tick adds the interval to the target once. The target then keeps gaining one interval per cycle while `count_i - cmp_target_o`, read as a signed value, is above zero. `lost_o` reports the number of these extra advances.
- R4: The behind/ahead test is a signed difference, so it gives the right answer when the counter or target wraps through zero.
- R5: The update flag (bit 4) fires when update is enabled and `sec_i` differs from the seconds value last recorded (0 after reset). When it fires, that seconds value is recorded.
- R6: The alarm flag (bit 5) fires when the alarm enable is set and hours, minutes and seconds all equal the alarm inputs. The periodic enable has no effect on it.
- R7: With periodic enabled and `per_div_i` nonzero, each serviced tick adds lost+1 to a divider count. The periodic flag (bit 6) fires when the count reaches `per_div_i`, and the count then returns to 0.
- R8: With periodic enabled and `per_div_i` equal to 0, the interval is `per_delta_i` and the periodic flag fires on every serviced tick.
- R9: When any flag fires, `irq_o` pulses for exactly one cycle and `flags_o` carries bit 7 set and the value 1 in bits 15:8. A serviced tick with no flag leaves `irq_o` low and sets `flags_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Comparator match pulse |
| count_i | input | CNT_W | Current free-running counter value |
| en_upd_i | input | 1 | Update interrupt enable |
| en_alm_i | input | 1 | Alarm interrupt enable |
| en_per_i | input | 1 | Periodic interrupt enable |
| sec_i | input | TIME_W | Current seconds |
| min_i | input | TIME_W | Current minutes |
| hour_i | input | TIME_W | Current hours |
| alm_sec_i | input | TIME_W | Alarm seconds |
| alm_min_i | input | TIME_W | Alarm minutes |
| alm_hour_i | input | TIME_W | Alarm hours |
| per_div_i | input | DIV_W | Base ticks per periodic event; 0 selects high-rate mode |
| per_delta_i | input | CNT_W | Interval in counter ticks for high-rate mode |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flags_o | output | 16 | Source flags, summary bit and count field |
| lost_o | output | LOST_W | Lost ticks on the last serviced tick |
| cmp_en_o | output | 1 | Comparator enable |
| cmp_target_o | output | CNT_W | Comparator target |

## Verification
The bench builds the block with `TICKS_PER_SEC` set to 6400, which gives a base interval of 100 counter ticks. At that size every target value and every catch-up step can be followed by hand. The bench holds `count_i` still while a tick is being serviced, so each lost count is exact. Because the counter stays 32 bits wide, a target just below the wrap point and a counter just above it put the signed comparison to the test. The divide value of 4 keeps the divider's wrap to a handful of ticks.

// File: rtl/rtc_irq_emul.sv
`timescale 1ns/1ps
module rtc_irq_emul #(
  parameter int CNT_W         = 32,
  parameter int TICKS_PER_SEC = 14318180,
  parameter int RATE_SHIFT    = 6,
  parameter int TIME_W        = 8,
  parameter int DIV_W         = 8,
  parameter int LOST_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              en_upd_i,
  input  logic              en_alm_i,
  input  logic              en_per_i,
  input  logic [TIME_W-1:0] sec_i,
  input  logic [TIME_W-1:0] min_i,
  input  logic [TIME_W-1:0] hour_i,
  input  logic [TIME_W-1:0] alm_sec_i,
  input  logic [TIME_W-1:0] alm_min_i,
  input  logic [TIME_W-1:0] alm_hour_i,
  input  logic [DIV_W-1:0]  per_div_i,
  input  logic [CNT_W-1:0]  per_delta_i,
  output logic              irq_o,
  output logic [15:0]       flags_o,
  output logic [LOST_W-1:0] lost_o,
  output logic              cmp_en_o,
  output logic [CNT_W-1:0]  cmp_target_o
);
  localparam logic [CNT_W-1:0] BASE_DELTA = CNT_W'(TICKS_PER_SEC >> RATE_SHIFT);
  localparam int SW = ((DIV_W > LOST_W) ? DIV_W : LOST_W) + 2;

  logic              busy;
  logic [LOST_W-1:0] run;
  logic [TIME_W-1:0] prev_sec;
  logic [SW-1:0]     pie_cnt;

  wire              en_any  = en_upd_i | en_alm_i | en_per_i;
  wire              hi_rate = en_per_i && (per_div_i == '0);
  wire [CNT_W-1:0]  delta   = hi_rate ? per_delta_i : BASE_DELTA;
  wire [CNT_W-1:0]  gap     = count_i - cmp_target_o;
  wire              behind  = !gap[CNT_W-1] && (gap != '0);

  wire              upd_hit = en_upd_i && (sec_i != prev_sec);
  wire              alm_hit = en_alm_i && (sec_i == alm_sec_i) &&
                              (min_i == alm_min_i) && (hour_i == alm_hour_i);
  wire [SW-1:0]     per_sum = pie_cnt + SW'(run) + SW'(1);
  wire              per_hit = en_per_i && (per_sum >= SW'(per_div_i));
  wire [2:0]        hits    = {per_hit, alm_hit, upd_hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      run          <= '0;
      prev_sec     <= '0;
      pie_cnt      <= '0;
      irq_o        <= 1'b0;
      flags_o      <= '0;
      lost_o       <= '0;
      cmp_en_o     <= 1'b0;
      cmp_target_o <= '0;
    end else begin
      irq_o <= 1'b0;
      if (!en_any) begin
        cmp_en_o <= 1'b0;
      end else if (!cmp_en_o) begin
        cmp_en_o     <= 1'b1;
        cmp_target_o <= count_i + delta;
      end

      if (!busy) begin
        if (tick_i && cmp_en_o && en_any) begin
          busy         <= 1'b1;
          run          <= '0;
          cmp_target_o <= cmp_target_o + delta;
        end
      end else if (behind) begin
        cmp_target_o <= cmp_target_o + delta;
        if (run != '1) run <= run + 1'b1;
      end else begin
        busy   <= 1'b0;
        lost_o <= run;
        if (upd_hit) prev_sec <= sec_i;
        if (en_per_i) pie_cnt <= per_hit ? '0 : per_sum;
        irq_o   <= |hits;
        flags_o <= (|hits) ? {8'd1, 1'b1, hits, 4'b0000} : 16'h0000;
      end
    end
  end
endmodule

module rtc_irq_emul_chk #(
  parameter int CNT_W         = 32,
  parameter int TICKS_PER_SEC = 14318180,
  parameter int RATE_SHIFT    = 6,
  parameter int TIME_W        = 8,
  parameter int DIV_W         = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  count_i,
  input logic              en_upd_i,
  input logic              en_alm_i,
  input logic              en_per_i,
  input logic [TIME_W-1:0] sec_i,
  input logic [TIME_W-1:0] min_i,
  input logic [TIME_W-1:0] hour_i,
  input logic [TIME_W-1:0] alm_sec_i,
  input logic [TIME_W-1:0] alm_min_i,
  input logic [TIME_W-1:0] alm_hour_i,
  input logic [DIV_W-1:0]  per_div_i,
  input logic              irq_o,
  input logic [15:0]       flags_o,
  input logic              cmp_en_o,
  input logic [CNT_W-1:0]  cmp_target_o
);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(TICKS_PER_SEC >> RATE_SHIFT);
  wire en_any = en_upd_i | en_alm_i | en_per_i;
  wire alm_eq = (sec_i == alm_sec_i) && (min_i == alm_min_i) && (hour_i == alm_hour_i);

  a_r2_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_any |=> !cmp_en_o);
  a_r1_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (en_any && !cmp_en_o && !(en_per_i && per_div_i == '0)) |=>
      (cmp_en_o && cmp_target_o == $past(count_i) + BASE));
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r9_word: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o[7] && flags_o[15:8] == 8'd1 && flags_o[6:4] != 3'd0));
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_any));
  a_r6_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[5]) |-> ($past(en_alm_i) && $past(alm_eq)));
  a_r5_update: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[4]) |-> $past(en_upd_i));
endmodule

bind rtc_irq_emul rtc_irq_emul_chk #(
  .CNT_W(CNT_W), .TICKS_PER_SEC(TICKS_PER_SEC), .RATE_SHIFT(RATE_SHIFT),
  .TIME_W(TIME_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i),
  .en_upd_i(en_upd_i), .en_alm_i(en_alm_i), .en_per_i(en_per_i),
  .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
  .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hour_i(alm_hour_i),
  .per_div_i(per_div_i), .irq_o(irq_o), .flags_o(flags_o),
  .cmp_en_o(cmp_en_o), .cmp_target_o(cmp_target_o)
);

// File: tb/rtc_irq_emul_tb.sv
`timescale 1ns/1ps
module rtc_irq_emul_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [31:0] count_i = '0;
  logic        en_upd_i = 1'b0, en_alm_i = 1'b0, en_per_i = 1'b0;
  logic [7:0]  sec_i = '0, min_i = '0, hour_i = '0;
  logic [7:0]  alm_sec_i = '0, alm_min_i = '0, alm_hour_i = '0;
  logic [7:0]  per_div_i = '0;
  logic [31:0] per_delta_i = '0;
  logic        irq_o;
  logic [15:0] flags_o;
  logic [7:0]  lost_o;
  logic        cmp_en_o;
  logic [31:0] cmp_target_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_irq_emul #(.TICKS_PER_SEC(6400)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_i(count_i),
    .en_upd_i(en_upd_i), .en_alm_i(en_alm_i), .en_per_i(en_per_i),
    .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
    .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hour_i(alm_hour_i),
    .per_div_i(per_div_i), .per_delta_i(per_delta_i),
    .irq_o(irq_o), .flags_o(flags_o), .lost_o(lost_o),
    .cmp_en_o(cmp_en_o), .cmp_target_o(cmp_target_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_en(input logic u, input logic a, input logic p, input logic [31:0] cnt);
    @(negedge clk);
    count_i = cnt; en_upd_i = u; en_alm_i = a; en_per_i = p;
    cycles(2);
  endtask

  task automatic do_tick(input string req, input logic [31:0] cnt, input logic [15:0] exp_flags,
                         input logic [7:0] exp_lost, input logic [31:0] exp_tgt);
    int pulses = 0;
    @(negedge clk);
    count_i = cnt; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (irq_o) pulses++;
      @(negedge clk);
    end
    chk(req, "irq pulses", pulses, (exp_flags != 0) ? 1 : 0);
    chk(req, "flags", flags_o, exp_flags);
    chk(req, "lost", lost_o, exp_lost);
    chk(req, "target", cmp_target_o, exp_tgt);
  endtask

  task automatic t_reset;
    chk("R9", "reset irq", irq_o, 0);
    chk("R9", "reset flags", flags_o, 0);
    chk("R2", "reset cmp_en", cmp_en_o, 0);
    chk("R3", "reset lost", lost_o, 0);
  endtask

  task automatic t_rearm_update;
    set_en(1, 0, 0, 32'd1000);
    chk("R1", "cmp_en after enable", cmp_en_o, 1);
    chk("R1", "target after enable", cmp_target_o, 32'd1100);
    sec_i = 8'd5;
    do_tick("R5", 32'd1050, 16'h0190, 0, 32'd1200);
    do_tick("R5", 32'd1150, 16'h0000, 0, 32'd1300);
  endtask

  task automatic t_alarm;
    alm_hour_i = 8'd1; alm_min_i = 8'd2; alm_sec_i = 8'd3;
    hour_i = 8'd1; min_i = 8'd2; sec_i = 8'd5;
    en_per_i = 1'b1; per_div_i = 8'd200;
    do_tick("R6", 32'd1250, 16'h0000, 0, 32'd1400);
    en_per_i = 1'b0;
    en_alm_i = 1'b1; sec_i = 8'd3;
    do_tick("R6", 32'd1350, 16'h01B0, 0, 32'd1500);
    min_i = 8'd9;
    do_tick("R6", 32'd1450, 16'h0000, 0, 32'd1600);
  endtask

  task automatic t_disable;
    set_en(0, 0, 0, 32'd1500);
    chk("R2", "cmp_en cleared", cmp_en_o, 0);
    do_tick("R2", 32'd9000, 16'h0000, 0, 32'd1600);
  endtask

  task automatic t_catchup_periodic;
    per_div_i = 8'd4;
    set_en(0, 0, 1, 32'd1000);
    chk("R1", "target periodic low rate", cmp_target_o, 32'd1100);
    do_tick("R3", 32'd1450, 16'h01C0, 8'd3, 32'd1500);
    do_tick("R7", 32'd1550, 16'h0000, 0, 32'd1600);
    do_tick("R7", 32'd1650, 16'h0000, 0, 32'd1700);
    do_tick("R7", 32'd1750, 16'h0000, 0, 32'd1800);
    do_tick("R7", 32'd1850, 16'h01C0, 0, 32'd1900);
  endtask

  task automatic t_wrap;
    set_en(0, 0, 0, 32'd0);
    per_div_i = 8'd1;
    set_en(0, 0, 1, 32'hFFFF_FF00);
    chk("R4", "target near wrap", cmp_target_o, 32'hFFFF_FF64);
    do_tick("R4", 32'h0000_0010, 16'h01C0, 8'd1, 32'h0000_002C);
  endtask

  task automatic t_high_rate;
    set_en(0, 0, 0, 32'd0);
    per_div_i = 8'd0; per_delta_i = 32'd30;
    set_en(0, 0, 1, 32'd500);
    chk("R8", "target high rate", cmp_target_o, 32'd530);
    do_tick("R8", 32'd520, 16'h01C0, 0, 32'd560);
    do_tick("R8", 32'd570, 16'h01C0, 0, 32'd590);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cycles(4);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_rearm_update();
    t_alarm();
    t_disable();
    t_catchup_periodic();
    t_wrap();
    t_high_rate();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule